// File: doc/BRIEF.md
# Sector Erase Collection Window Timer

This block sits beside a flash device's command decoder. It gathers sector erase requests into a set of pending sectors and holds off the embedded erase until the host has been quiet for a programmable number of clock cycles. Each sector request that is accepted adds its sector to the pending bitmap and restarts the full quiet window. When the window runs out, the block raises its window-closed status bit, the bit a host polls on the status bus as DQ3, and pulses an erase-start strobe to the erase engine.

From that moment on, new sector and chip erase requests are dropped. The only command still honoured is erase suspend, which is forwarded as a one-cycle request. A chip erase issued while the block is idle skips the window. It marks every sector pending and starts the engine at once. Erase-done from the engine, or the synchronous reset, empties the bitmap and reopens the block for new requests.

The window length is a parameter in clock cycles. The default of 2500 cycles gives 50 µs at 50 MHz. A host that spaces its sector requests more closely than the window never needs to poll the status bit.

Top module: `sector_erase_window_timer`

## Requirements
- R1: While `rst` is high and on the cycle after it is released, `win_closed_o`, `busy_o`, `start_o`, `susp_req_o` and every bit of `pend_map_o` read 0.
- R2: When the block is idle and `sec_cmd_i` is sampled high with `chip_cmd_i` low, on the next cycle bit `sec_idx_i` of `pend_map_o` is 1 (bit i stands for sector i), `busy_o` is 1 and `win_closed_o` is 0.
- R3: While the window is open, an accepted sector request sets its bitmap bit and restarts the window. `win_closed_o` first reads 1 exactly WINDOW_CYCLES clock edges after the edge that sampled the last accepted request.
- R4: `start_o` is high for exactly one cycle: the first cycle in which `win_closed_o` reads 1.
- R5: A sector request sampled on the same edge on which the window expires is rejected, and its bit is not added to the bitmap.
- R6: While `win_closed_o` is 1, sector and chip erase requests are ignored: the bitmap is unchanged and `start_o` stays 0. A chip erase request made while the window is open is also ignored.
- R7: An erase suspend sampled while `win_closed_o` is 1, with `erase_done_i` low, gives `susp_req_o` = 1 on the next cycle for one cycle and leaves the bitmap unchanged. A suspend in any other state gives no request.
- R8: A chip erase request sampled while the block is idle gives, on the next cycle, `start_o` = 1, `win_closed_o` = 1, `busy_o` = 1 and every bitmap bit set. There is no collection window.
- R9: `erase_done_i` sampled while `win_closed_o` is 1 gives, on the next cycle, a bitmap of all zeros with `win_closed_o` = 0 and `busy_o` = 0. In any other state `erase_done_i` has no effect.
- R10: Raising `rst` in the middle of an operation clears all outputs on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_cmd_i | input | 1 | Decoded sector erase request strobe |
| sec_idx_i | input | IDX_W | Sector index of the request |
| chip_cmd_i | input | 1 | Decoded chip erase request strobe |
| susp_cmd_i | input | 1 | Decoded erase suspend strobe |
| erase_done_i | input | 1 | Erase engine finished |
| win_closed_o | output | 1 | Window closed, erase running (DQ3 status bit) |
| pend_map_o | output | NUM_SECTORS | Sectors pending erase |
| start_o | output | 1 | One-cycle erase start pulse |
| busy_o | output | 1 | Block is collecting or erasing |
| susp_req_o | output | 1 | One-cycle suspend request to the engine |

## Verification
The hardest case to reach is a sector request that lands on the exact edge where the window expires. Random traffic almost never hits that edge, because any earlier request moves the deadline. The bench therefore reaches it directly: it issues one request, stays quiet for WINDOW_CYCLES-1 edges, and then issues a second request on the expiry edge. It checks that this second sector is missing from the bitmap while the start pulse fires. Random bursts with a different request density in each segment then alternate between windows that keep restarting and windows that expire.

// File: rtl/sew_pkg.sv
package sew_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_ERASE   = 2'd2
  } sew_state_e;
endpackage

// File: rtl/sew_window_cnt.sv
module sew_window_cnt #(
  parameter int WINDOW_CYCLES = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WINDOW_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= LOAD_VAL;
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = run_i && (cnt_q == '0);

  // R3: the down-counter never leaves its loaded range
  a_r3_count_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LOAD_VAL);

  // R3: a running counter that is not reloaded moves down by one
  a_r3_counts_down: assert property (@(posedge clk) disable iff (rst)
    (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sew_pend_map.sv
module sew_pend_map #(
  parameter int NUM_SECTORS = 16,
  parameter int IDX_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clear_i,
  input  logic                   fill_i,
  input  logic                   add_i,
  input  logic [IDX_W-1:0]       add_idx_i,
  output logic [NUM_SECTORS-1:0] map_o
);
  logic [NUM_SECTORS-1:0] map_q;

  for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clear_i) begin
        map_q[i] <= 1'b0;
      end else if (fill_i) begin
        map_q[i] <= 1'b1;
      end else if (add_i && add_idx_i == IDX_W'(i)) begin
        map_q[i] <= 1'b1;
      end
    end
  end

  assign map_o = map_q;

  // R2: without a clear, a pending bit is never dropped
  a_r2_bits_never_drop: assert property (@(posedge clk) disable iff (rst)
    !clear_i |=> (($past(map_q) & ~map_q) == '0));

  // R9: a clear empties the map on the next edge
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (map_q == '0));
endmodule

// File: rtl/sew_ctrl.sv
module sew_ctrl
  import sew_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sec_cmd_i,
  input  logic chip_cmd_i,
  input  logic susp_cmd_i,
  input  logic erase_done_i,
  input  logic win_expired_i,
  output logic win_load_o,
  output logic win_run_o,
  output logic map_add_o,
  output logic map_fill_o,
  output logic map_clear_o,
  output logic win_closed_o,
  output logic busy_o,
  output logic start_o,
  output logic susp_req_o
);
  sew_state_e state_q, state_d;
  logic closed_q, busy_q, start_q, susp_q;
  logic idle_chip, idle_sec, coll_sec, go_erase;

  assign idle_chip = (state_q == ST_IDLE) && chip_cmd_i;
  assign idle_sec  = (state_q == ST_IDLE) && !chip_cmd_i && sec_cmd_i;
  assign coll_sec  = (state_q == ST_COLLECT) && !win_expired_i && sec_cmd_i;
  assign go_erase  = idle_chip || ((state_q == ST_COLLECT) && win_expired_i);

  assign win_load_o  = idle_sec || coll_sec;
  assign map_add_o   = idle_sec || coll_sec;
  assign map_fill_o  = idle_chip;
  assign map_clear_o = (state_q == ST_ERASE) && erase_done_i;
  assign win_run_o   = (state_q == ST_COLLECT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (chip_cmd_i)     state_d = ST_ERASE;
        else if (sec_cmd_i) state_d = ST_COLLECT;
      end
      ST_COLLECT: begin
        if (win_expired_i)  state_d = ST_ERASE;
      end
      ST_ERASE: begin
        if (erase_done_i)   state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      closed_q <= 1'b0;
      busy_q   <= 1'b0;
      start_q  <= 1'b0;
      susp_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      closed_q <= (state_d == ST_ERASE);
      busy_q   <= (state_d != ST_IDLE);
      start_q  <= go_erase;
      susp_q   <= (state_q == ST_ERASE) && !erase_done_i && susp_cmd_i;
    end
  end

  assign win_closed_o = closed_q;
  assign busy_o       = busy_q;
  assign start_o      = start_q;
  assign susp_req_o   = susp_q;

  // R4: the start pulse never lasts two cycles
  a_r4_start_one_cycle: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  // R7: a suspend request only appears while the window is closed
  a_r7_susp_only_closed: assert property (@(posedge clk) disable iff (rst)
    susp_req_o |-> win_closed_o);

  // R9: erase done while erasing returns the block to idle
  a_r9_done_returns_idle: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_ERASE) && erase_done_i) |=> (!win_closed_o && !busy_o));

  // R2: a closed window always implies busy
  a_r2_closed_implies_busy: assert property (@(posedge clk) disable iff (rst)
    win_closed_o |-> busy_o);
endmodule

// File: rtl/sector_erase_window_timer.sv
module sector_erase_window_timer #(
  parameter int NUM_SECTORS   = 16,
  parameter int WINDOW_CYCLES = 2500,
  parameter int IDX_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sec_cmd_i,
  input  logic [IDX_W-1:0]       sec_idx_i,
  input  logic                   chip_cmd_i,
  input  logic                   susp_cmd_i,
  input  logic                   erase_done_i,
  output logic                   win_closed_o,
  output logic [NUM_SECTORS-1:0] pend_map_o,
  output logic                   start_o,
  output logic                   busy_o,
  output logic                   susp_req_o
);
  logic win_load, win_run, win_expired;
  logic map_add, map_fill, map_clear;

  sew_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .sec_cmd_i    (sec_cmd_i),
    .chip_cmd_i   (chip_cmd_i),
    .susp_cmd_i   (susp_cmd_i),
    .erase_done_i (erase_done_i),
    .win_expired_i(win_expired),
    .win_load_o   (win_load),
    .win_run_o    (win_run),
    .map_add_o    (map_add),
    .map_fill_o   (map_fill),
    .map_clear_o  (map_clear),
    .win_closed_o (win_closed_o),
    .busy_o       (busy_o),
    .start_o      (start_o),
    .susp_req_o   (susp_req_o)
  );

  sew_window_cnt #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load_i   (win_load),
    .run_i    (win_run),
    .expired_o(win_expired)
  );

  sew_pend_map #(.NUM_SECTORS(NUM_SECTORS), .IDX_W(IDX_W)) u_map (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (map_clear),
    .fill_i   (map_fill),
    .add_i    (map_add),
    .add_idx_i(sec_idx_i),
    .map_o    (pend_map_o)
  );

  // R6: with the window closed and no erase-done, the bitmap holds
  a_r6_map_frozen_closed: assert property (@(posedge clk) disable iff (rst)
    (win_closed_o && !erase_done_i) |=> $stable(pend_map_o));

  // R8: chip erase from idle starts at once with all sectors pending
  a_r8_chip_immediate: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && chip_cmd_i) |=> (start_o && win_closed_o && (&pend_map_o)));

  // R4: the start pulse coincides with the window closing
  a_r4_start_with_close: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (win_closed_o && !$past(win_closed_o)));

  // R10: reset clears everything on the next edge
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!win_closed_o && !busy_o && !start_o && !susp_req_o && pend_map_o == '0));
endmodule

// File: tb/sector_erase_window_timer_tb.sv
module sector_erase_window_timer_tb;
  localparam int NS = 8;
  localparam int W  = 20;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sec_cmd = 1'b0, chip_cmd = 1'b0, susp_cmd = 1'b0, done = 1'b0;
  logic [IW-1:0] sec_idx = '0;
  logic win_closed, start, busy, susp_req;
  logic [NS-1:0] pend_map;

  always #10 clk = ~clk;

  sector_erase_window_timer #(.NUM_SECTORS(NS), .WINDOW_CYCLES(W), .IDX_W(IW)) u_dut (
    .clk(clk), .rst(rst), .sec_cmd_i(sec_cmd), .sec_idx_i(sec_idx),
    .chip_cmd_i(chip_cmd), .susp_cmd_i(susp_cmd), .erase_done_i(done),
    .win_closed_o(win_closed), .pend_map_o(pend_map), .start_o(start),
    .busy_o(busy), .susp_req_o(susp_req)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference model: 0 idle, 1 collecting, 2 erasing
  int m_state = 0;
  int m_cnt = 0;
  logic [NS-1:0] m_map = '0;
  logic m_start = 0, m_susp = 0;
  string last_tag = "R1";

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "win_closed", 32'(win_closed), 32'(m_state == 2));
    chk(tag, "busy", 32'(busy), 32'(m_state != 0));
    chk(tag, "start", 32'(start), 32'(m_start));
    chk(tag, "susp_req", 32'(susp_req), 32'(m_susp));
    chk(tag, "pend_map", 32'(pend_map), 32'(m_map));
  endtask

  function automatic void model(bit s, logic [IW-1:0] ix, bit c, bit sp, bit d, bit r);
    m_start = 0;
    m_susp = 0;
    if (r) begin
      m_state = 0; m_cnt = 0; m_map = '0;
    end else begin
      case (m_state)
        0: begin
          if (c) begin m_state = 2; m_map = '1; m_start = 1; end
          else if (s) begin m_state = 1; m_map[ix] = 1'b1; m_cnt = W - 1; end
        end
        1: begin
          if (m_cnt == 0) begin m_state = 2; m_start = 1; end
          else begin
            m_cnt = m_cnt - 1;
            if (s) begin m_map[ix] = 1'b1; m_cnt = W - 1; end
          end
        end
        default: begin
          if (d) begin m_state = 0; m_map = '0; end
          else if (sp) m_susp = 1;
        end
      endcase
    end
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic step(bit s, logic [IW-1:0] ix, bit c, bit sp, bit d, bit r, string tag);
    compare(last_tag);
    sec_cmd = s; sec_idx = ix; chip_cmd = c; susp_cmd = sp; done = d; rst = r;
    model(s, ix, c, sp, d, r);
    last_tag = tag;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    step(0, '0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    int dens;
    void'($urandom(32'd1234));
    @(negedge clk);
    step(0, '0, 0, 0, 0, 1, "R1");
    step(0, '0, 0, 0, 0, 1, "R1");
    idle("R1");
    chk("R1", "win_closed after reset", 32'(win_closed), 0);
    chk("R1", "pend_map after reset", 32'(pend_map), 0);
    chk("R1", "busy after reset", 32'(busy), 0);

    // R2: first sector request opens the window
    step(1, 3'd5, 0, 0, 0, 0, "R2");
    chk("R2", "pend_map", 32'(pend_map), 32'h20);
    chk("R2", "busy", 32'(busy), 1);
    chk("R2", "win_closed", 32'(win_closed), 0);

    // R3: second request restarts the window, then measure
    idle("R3"); idle("R3");
    step(1, 3'd2, 0, 0, 0, 0, "R3");
    n = 0;
    while (win_closed == 1'b0 && n < 4 * W) begin
      idle("R3");
      n++;
    end
    chk("R3", "edges to close", 32'(n), 32'(W));
    chk("R3", "pend_map", 32'(pend_map), 32'h24);
    chk("R4", "start on close", 32'(start), 1);
    idle("R4");
    chk("R4", "start drops", 32'(start), 0);

    // R6: requests ignored while closed
    step(1, 3'd1, 0, 0, 0, 0, "R6");
    chk("R6", "sector ignored map", 32'(pend_map), 32'h24);
    step(0, '0, 1, 0, 0, 0, "R6");
    chk("R6", "chip ignored map", 32'(pend_map), 32'h24);
    chk("R6", "chip ignored start", 32'(start), 0);

    // R7: suspend passes through as a pulse
    step(0, '0, 0, 1, 0, 0, "R7");
    chk("R7", "susp_req", 32'(susp_req), 1);
    chk("R7", "map kept", 32'(pend_map), 32'h24);
    idle("R7");
    chk("R7", "susp_req drops", 32'(susp_req), 0);

    // R9: done clears
    step(0, '0, 0, 0, 1, 0, "R9");
    chk("R9", "map cleared", 32'(pend_map), 0);
    chk("R9", "win_closed cleared", 32'(win_closed), 0);
    chk("R9", "busy cleared", 32'(busy), 0);

    // R7: suspend while idle does nothing
    step(0, '0, 0, 1, 0, 0, "R7");
    chk("R7", "idle suspend", 32'(susp_req), 0);

    // R5: request on the expiry edge is rejected
    step(1, 3'd0, 0, 0, 0, 0, "R5");
    for (int i = 0; i < W - 1; i++) idle("R5");
    step(1, 3'd7, 0, 0, 0, 0, "R5");
    chk("R5", "late sector absent", 32'(pend_map), 32'h01);
    chk("R5", "closed", 32'(win_closed), 1);
    chk("R5", "start", 32'(start), 1);
    step(0, '0, 0, 0, 1, 0, "R9");

    // R8: chip erase from idle
    step(0, '0, 1, 0, 0, 0, "R8");
    chk("R8", "start", 32'(start), 1);
    chk("R8", "closed", 32'(win_closed), 1);
    chk("R8", "map full", 32'(pend_map), 32'hFF);
    chk("R8", "busy", 32'(busy), 1);
    step(0, '0, 0, 0, 1, 0, "R9");

    // R6 / R9: chip and done ignored while collecting
    step(1, 3'd3, 0, 0, 0, 0, "R2");
    step(0, '0, 1, 0, 0, 0, "R6");
    chk("R6", "chip in window map", 32'(pend_map), 32'h08);
    chk("R6", "chip in window start", 32'(start), 0);
    chk("R6", "chip in window closed", 32'(win_closed), 0);
    step(0, '0, 0, 0, 1, 0, "R9");
    chk("R9", "done in window ignored", 32'(busy), 1);
    chk("R9", "done in window map", 32'(pend_map), 32'h08);

    // R10: reset mid-operation
    step(0, '0, 0, 0, 0, 1, "R10");
    chk("R10", "map", 32'(pend_map), 0);
    chk("R10", "busy", 32'(busy), 0);

    // constrained random segments
    for (int seg = 0; seg < 20; seg++) begin
      dens = (seg % 3 == 0) ? 2 : ((seg % 3 == 1) ? 8 : 40);
      for (int c = 0; c < 200; c++) begin
        bit s, ch, sp, d, r;
        string tg;
        s  = ($urandom % 100) < dens;
        ch = ($urandom % 100) < 2;
        sp = ($urandom % 100) < 10;
        d  = ($urandom % 100) < ((m_state == 2) ? 4 : 2);
        r  = ($urandom % 1000) < 3;
        tg = r ? "R10" : (m_state == 0 ? "R2" : (m_state == 1 ? "R3" : "R6"));
        step(s, IW'($urandom), ch, sp, d, r, tg);
      end
    end
    idle("R3");
    compare(last_tag);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule